// File: doc/BRIEF.md
# Multi-mode panel video timing generator

The block produces the raster timing for a small delta-RGB TFT panel from a single dot clock. It drives active-low horizontal and vertical sync pulses, each one clock wide, and a data-enable. It also drives a pixel column counter and a line row counter that count inside the visible area. A two-bit mode input selects one of four horizontal profiles, and each profile implies a vertical profile. A separate input chooses between progressive and interlaced scanning. In interlaced scanning the porches differ by half a line between the two fields. The block places the second field's vertical sync at the middle of a line to produce that half line.

Both configuration inputs are captured only on the last clock of a frame, so a change never produces a partly formed frame. A field flag shows which field is being scanned. Pixel formatting, clock generation and panel configuration are handled elsewhere.

Top module: `panel_timing_gen`

## Requirements
- R1: The horizontal sync is low for exactly one clock at position 0 of every line. A line lasts 659 clocks in mode 0 (through), 1716 clocks in mode 1 (YUV, NTSC), 1728 clocks in mode 2 (YUV, PAL) and 1560 clocks in mode 3 (RGB dummy).
- R2: The horizontal visible window begins at the back-porch count, which includes the sync clock. The back porch is 96 clocks in mode 0 and 240 clocks in the other modes. The window lasts 480 clocks in mode 0, 1440 clocks in modes 1 and 2, and 1280 clocks in mode 3.
- R3: With progressive scanning, the vertical sync is low for one clock at clock 0 of line 0. A frame lasts 262 lines in modes 0, 1 and 3, and 312 lines in mode 2. Visible rows start after a back porch of 14 lines in mode 0, 21 lines in modes 1 and 3, and 24 lines in mode 2. There are 240 visible rows, or 288 in mode 2.
- R4: With interlaced scanning, a frame holds 2T+1 lines, where T is the progressive total. The second field's vertical sync falls on line T at clock floor(H/2), where H is the line length.
- R5: In the second field the visible rows begin on line T+1+B, where B is the progressive back porch. The first field uses the progressive row window.
- R6: The data-enable is high exactly where the horizontal and vertical visible windows overlap.
- R7: While the data-enable is high, the pixel counter runs from 0 across each visible line and the line counter runs from 0 across the visible rows of the current field. While the data-enable is low, both counters read 0.
- R8: The field flag reads 0 in progressive scanning. In interlaced scanning it reads 0 from the frame start and 1 from the second field's vertical sync clock up to the end of the frame.
- R9: The mode and the interlace select are sampled only on the last clock of a frame. Changes at any other time have no effect on the frame in progress.
- R10: An asynchronous active-low reset returns the block to line 0, clock 0, mode 0 and progressive scanning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Profile select: 0 through, 1 YUV NTSC, 2 YUV PAL, 3 RGB dummy |
| interlace_i | input | 1 | 1 selects interlaced scanning |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data-enable for the visible area |
| field_o | output | 1 | 1 during the second interlaced field |
| pix_x_o | output | H_W | Visible column index |
| line_y_o | output | V_W | Visible row index within the field |

## Verification
Every mode is held steady for a whole frame, once progressive and once interlaced. The sync and data-enable totals over that frame separate the line lengths, the frame lengths and the window sizes of the eight combinations. A directed switch in the middle of a frame shows whether the old profile runs on until the frame boundary. A reset in the middle of a frame shows whether the position and configuration return to their reset values. Random switches of mode and scan type are then compared clock by clock against a reference model. These catch faults at the frame seam, where a stale or early configuration would misplace the half-line sync or the field flag.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    MODE_THRU      = 2'd0,
    MODE_YUV_NTSC  = 2'd1,
    MODE_YUV_PAL   = 2'd2,
    MODE_RGB_DUMMY = 2'd3
  } scan_mode_e;

  localparam int NUM_MODES = 4;
endpackage

// File: rtl/ptg_profile.sv
module ptg_profile
  import ptg_pkg::*;
#(
  parameter int H_W        = 11,
  parameter int V_W        = 10,
  parameter int H_THRU_ACT = 480,
  parameter int H_THRU_BP  = 96,
  parameter int H_THRU_FP  = 83,
  parameter int H_SER_BP   = 240,
  parameter int H_YUV_ACT  = 1440,
  parameter int H_NTSC_FP  = 36,
  parameter int H_PAL_FP   = 48,
  parameter int H_RGB_ACT  = 1280,
  parameter int H_RGB_FP   = 40,
  parameter int V_NTSC_ACT = 240,
  parameter int V_NTSC_TOT = 262,
  parameter int V_THRU_BP  = 14,
  parameter int V_SER_BP   = 21,
  parameter int V_PAL_ACT  = 288,
  parameter int V_PAL_TOT  = 312,
  parameter int V_PAL_BP   = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [1:0]     mode_i,
  input  logic           interlace_i,
  output logic [H_W-1:0] h_tot_o,
  output logic [H_W-1:0] h_bp_o,
  output logic [H_W-1:0] h_act_o,
  output logic [V_W-1:0] v_tot_o,
  output logic [V_W-1:0] v_bp_o,
  output logic [V_W-1:0] v_act_o,
  output logic           interlace_o
);
  localparam int H_THRU_TOT = H_THRU_BP + H_THRU_ACT + H_THRU_FP;
  localparam int H_NTSC_TOT = H_SER_BP + H_YUV_ACT + H_NTSC_FP;
  localparam int H_PAL_TOT  = H_SER_BP + H_YUV_ACT + H_PAL_FP;
  localparam int H_RGB_TOT  = H_SER_BP + H_RGB_ACT + H_RGB_FP;

  scan_mode_e mode_q;
  logic       il_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_THRU;
      il_q   <= 1'b0;
    end else if (load_i) begin
      mode_q <= scan_mode_e'(mode_i);
      il_q   <= interlace_i;
    end
  end

  // Per-mode horizontal lookup; one generate branch per profile slot
  logic [H_W-1:0] tot_tab [NUM_MODES];
  logic [H_W-1:0] bp_tab  [NUM_MODES];
  logic [H_W-1:0] act_tab [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_hprof
    if (g == int'(MODE_THRU)) begin : g_thru
      assign tot_tab[g] = H_W'(H_THRU_TOT);
      assign bp_tab[g]  = H_W'(H_THRU_BP);
      assign act_tab[g] = H_W'(H_THRU_ACT);
    end else if (g == int'(MODE_YUV_NTSC)) begin : g_ntsc
      assign tot_tab[g] = H_W'(H_NTSC_TOT);
      assign bp_tab[g]  = H_W'(H_SER_BP);
      assign act_tab[g] = H_W'(H_YUV_ACT);
    end else if (g == int'(MODE_YUV_PAL)) begin : g_pal
      assign tot_tab[g] = H_W'(H_PAL_TOT);
      assign bp_tab[g]  = H_W'(H_SER_BP);
      assign act_tab[g] = H_W'(H_YUV_ACT);
    end else begin : g_rgb
      assign tot_tab[g] = H_W'(H_RGB_TOT);
      assign bp_tab[g]  = H_W'(H_SER_BP);
      assign act_tab[g] = H_W'(H_RGB_ACT);
    end
  end

  assign h_tot_o = tot_tab[mode_q];
  assign h_bp_o  = bp_tab[mode_q];
  assign h_act_o = act_tab[mode_q];

  always_comb begin
    unique case (mode_q)
      MODE_THRU: begin
        v_tot_o = V_W'(V_NTSC_TOT);
        v_bp_o  = V_W'(V_THRU_BP);
        v_act_o = V_W'(V_NTSC_ACT);
      end
      MODE_YUV_PAL: begin
        v_tot_o = V_W'(V_PAL_TOT);
        v_bp_o  = V_W'(V_PAL_BP);
        v_act_o = V_W'(V_PAL_ACT);
      end
      default: begin
        v_tot_o = V_W'(V_NTSC_TOT);
        v_bp_o  = V_W'(V_SER_BP);
        v_act_o = V_W'(V_NTSC_ACT);
      end
    endcase
  end

  assign interlace_o = il_q;
endmodule

// File: rtl/ptg_hcount.sv
module ptg_hcount #(
  parameter int H_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] h_tot_i,
  input  logic [H_W-1:0] h_bp_i,
  input  logic [H_W-1:0] h_act_i,
  output logic [H_W-1:0] hcnt_o,
  output logic [H_W-1:0] h_half_o,
  output logic           line_end_o,
  output logic           h_win_o,
  output logic [H_W-1:0] x_o
);
  logic [H_W-1:0] hcnt_q;
  logic [H_W-1:0] h_win_end;

  assign line_end_o = (hcnt_q == h_tot_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hcnt_q <= '0;
    else if (line_end_o) hcnt_q <= '0;
    else                 hcnt_q <= hcnt_q + 1'b1;
  end

  assign h_win_end = h_bp_i + h_act_i;
  assign h_win_o   = (hcnt_q >= h_bp_i) && (hcnt_q < h_win_end);
  assign x_o       = h_win_o ? (hcnt_q - h_bp_i) : '0;
  assign h_half_o  = h_tot_i >> 1;
  assign hcnt_o    = hcnt_q;
endmodule

// File: rtl/ptg_vcount.sv
module ptg_vcount #(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           line_end_i,
  input  logic [H_W-1:0] hcnt_i,
  input  logic [H_W-1:0] h_half_i,
  input  logic [V_W-1:0] v_tot_i,
  input  logic [V_W-1:0] v_bp_i,
  input  logic [V_W-1:0] v_act_i,
  input  logic           il_i,
  output logic           frame_end_o,
  output logic           vsync_hit_o,
  output logic           field_o,
  output logic           v_win_o,
  output logic [V_W-1:0] y_o
);
  logic [V_W-1:0] vcnt_q;
  logic [V_W-1:0] v_last;
  logic [V_W-1:0] row;
  logic           mid_line;

  // Interlaced frame = two fields plus the shared split line
  assign v_last      = il_i ? (v_tot_i << 1) : (v_tot_i - 1'b1);
  assign frame_end_o = line_end_i && (vcnt_q == v_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vcnt_q <= '0;
    else if (frame_end_o) vcnt_q <= '0;
    else if (line_end_i)  vcnt_q <= vcnt_q + 1'b1;
  end

  assign mid_line = (vcnt_q == v_tot_i) && (hcnt_i >= h_half_i);
  assign field_o  = il_i && ((vcnt_q > v_tot_i) || mid_line);

  // Even-field rows re-based past the split line; split line wraps out of range
  assign row     = field_o ? (vcnt_q - v_tot_i - 1'b1) : vcnt_q;
  assign v_win_o = (row >= v_bp_i) && (row < v_bp_i + v_act_i);
  assign y_o     = v_win_o ? (row - v_bp_i) : '0;

  assign vsync_hit_o = ((vcnt_q == '0) && (hcnt_i == '0)) ||
                       (il_i && (vcnt_q == v_tot_i) && (hcnt_i == h_half_i));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
  parameter int H_W        = 11,
  parameter int V_W        = 10,
  parameter int H_THRU_ACT = 480,
  parameter int H_THRU_BP  = 96,
  parameter int H_THRU_FP  = 83,
  parameter int H_SER_BP   = 240,
  parameter int H_YUV_ACT  = 1440,
  parameter int H_NTSC_FP  = 36,
  parameter int H_PAL_FP   = 48,
  parameter int H_RGB_ACT  = 1280,
  parameter int H_RGB_FP   = 40,
  parameter int V_NTSC_ACT = 240,
  parameter int V_NTSC_TOT = 262,
  parameter int V_THRU_BP  = 14,
  parameter int V_SER_BP   = 21,
  parameter int V_PAL_ACT  = 288,
  parameter int V_PAL_TOT  = 312,
  parameter int V_PAL_BP   = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [1:0]     mode_i,
  input  logic           interlace_i,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic           field_o,
  output logic [H_W-1:0] pix_x_o,
  output logic [V_W-1:0] line_y_o
);
  logic [H_W-1:0] h_tot, h_bp, h_act, hcnt, h_half, x;
  logic [V_W-1:0] v_tot, v_bp, v_act, y;
  logic           cfg_il, line_end, frame_end, h_win, v_win, vsync_hit;

  ptg_profile #(
    .H_W(H_W), .V_W(V_W),
    .H_THRU_ACT(H_THRU_ACT), .H_THRU_BP(H_THRU_BP), .H_THRU_FP(H_THRU_FP),
    .H_SER_BP(H_SER_BP), .H_YUV_ACT(H_YUV_ACT), .H_NTSC_FP(H_NTSC_FP),
    .H_PAL_FP(H_PAL_FP), .H_RGB_ACT(H_RGB_ACT), .H_RGB_FP(H_RGB_FP),
    .V_NTSC_ACT(V_NTSC_ACT), .V_NTSC_TOT(V_NTSC_TOT), .V_THRU_BP(V_THRU_BP),
    .V_SER_BP(V_SER_BP), .V_PAL_ACT(V_PAL_ACT), .V_PAL_TOT(V_PAL_TOT),
    .V_PAL_BP(V_PAL_BP)
  ) u_profile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (frame_end),
    .mode_i      (mode_i),
    .interlace_i (interlace_i),
    .h_tot_o     (h_tot),
    .h_bp_o      (h_bp),
    .h_act_o     (h_act),
    .v_tot_o     (v_tot),
    .v_bp_o      (v_bp),
    .v_act_o     (v_act),
    .interlace_o (cfg_il)
  );

  ptg_hcount #(.H_W(H_W)) u_hcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .h_tot_i    (h_tot),
    .h_bp_i     (h_bp),
    .h_act_i    (h_act),
    .hcnt_o     (hcnt),
    .h_half_o   (h_half),
    .line_end_o (line_end),
    .h_win_o    (h_win),
    .x_o        (x)
  );

  ptg_vcount #(.H_W(H_W), .V_W(V_W)) u_vcount (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_end_i  (line_end),
    .hcnt_i      (hcnt),
    .h_half_i    (h_half),
    .v_tot_i     (v_tot),
    .v_bp_i      (v_bp),
    .v_act_i     (v_act),
    .il_i        (cfg_il),
    .frame_end_o (frame_end),
    .vsync_hit_o (vsync_hit),
    .field_o     (field_o),
    .v_win_o     (v_win),
    .y_o         (y)
  );

  assign hsync_o  = (hcnt != '0);
  assign vsync_o  = ~vsync_hit;
  assign de_o     = h_win && v_win;
  assign pix_x_o  = de_o ? x : '0;
  assign line_y_o = de_o ? y : '0;
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int H_W = 11,
  parameter int V_W = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hsync_o,
  input logic           vsync_o,
  input logic           de_o,
  input logic           field_o,
  input logic [H_W-1:0] pix_x_o,
  input logic [V_W-1:0] line_y_o,
  input logic           il_i
);
  AST_HSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |=> hsync_o); // R1
  AST_VSYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |=> vsync_o); // R3
  AST_DE_CLEAR_OF_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o && vsync_o)); // R6
  AST_PIX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(de_o)) |-> (pix_x_o == H_W'($past(pix_x_o) + 1'b1))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> ((pix_x_o == '0) && (line_y_o == '0))); // R7
  AST_FIELD_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !il_i |-> !field_o); // R8
  AST_FIELD_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(field_o) |-> !vsync_o); // R4
  AST_FIELD_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(field_o) |-> (!vsync_o && !hsync_o)); // R8
endmodule

bind panel_timing_gen ptg_checker #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hsync_o  (hsync_o),
  .vsync_o  (vsync_o),
  .de_o     (de_o),
  .field_o  (field_o),
  .pix_x_o  (pix_x_o),
  .line_y_o (line_y_o),
  .il_i     (cfg_il)
);

// File: tb/panel_timing_gen_tb_top.sv
`timescale 1ns/1ps
module panel_timing_gen_tb_top;
  localparam int HW = 11;
  localparam int VW = 10;
  // Scaled profile so frames are short
  localparam int HTA = 8,  HTB = 4, HTF = 3;
  localparam int SBP = 5,  YA  = 12, NF = 3, PF = 4;
  localparam int RA  = 10, RF  = 2;
  localparam int VNA = 6,  VNT = 11, VTB = 3, VSB = 4;
  localparam int VPA = 8,  VPT = 13, VPB = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          il = 1'b0;
  logic          hs, vs, de, fld;
  logic [HW-1:0] px;
  logic [VW-1:0] ly;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference position and latched configuration
  int mh = 0, mv = 0, mmode = 0;
  bit mil = 1'b0;

  always #2.5 clk = ~clk;

  panel_timing_gen #(
    .H_W(HW), .V_W(VW),
    .H_THRU_ACT(HTA), .H_THRU_BP(HTB), .H_THRU_FP(HTF),
    .H_SER_BP(SBP), .H_YUV_ACT(YA), .H_NTSC_FP(NF), .H_PAL_FP(PF),
    .H_RGB_ACT(RA), .H_RGB_FP(RF),
    .V_NTSC_ACT(VNA), .V_NTSC_TOT(VNT), .V_THRU_BP(VTB), .V_SER_BP(VSB),
    .V_PAL_ACT(VPA), .V_PAL_TOT(VPT), .V_PAL_BP(VPB)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .interlace_i(il),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .field_o(fld),
    .pix_x_o(px), .line_y_o(ly)
  );

  function automatic int f_hbp(int m);  return (m == 0) ? HTB : SBP; endfunction
  function automatic int f_hact(int m);
    return (m == 0) ? HTA : (m == 3) ? RA : YA;
  endfunction
  function automatic int f_htot(int m);
    case (m)
      0: return HTB + HTA + HTF;
      1: return SBP + YA + NF;
      2: return SBP + YA + PF;
      default: return SBP + RA + RF;
    endcase
  endfunction
  function automatic int f_vtot(int m); return (m == 2) ? VPT : VNT; endfunction
  function automatic int f_vact(int m); return (m == 2) ? VPA : VNA; endfunction
  function automatic int f_vbp(int m);
    return (m == 0) ? VTB : (m == 2) ? VPB : VSB;
  endfunction
  function automatic int f_frame(int m, bit i);
    return f_htot(m) * (i ? 2 * f_vtot(m) + 1 : f_vtot(m));
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int  half, t, row, ex, ey;
    bit  e_fld, e_vs, hw, vw, e_de;
    half  = f_htot(mmode) / 2;
    t     = f_vtot(mmode);
    e_fld = mil && ((mv > t) || (mv == t && mh >= half));
    e_vs  = !((mv == 0 && mh == 0) || (mil && mv == t && mh == half));
    row   = e_fld ? mv - t - 1 : mv;
    hw    = (mh >= f_hbp(mmode)) && (mh < f_hbp(mmode) + f_hact(mmode));
    vw    = (row >= f_vbp(mmode)) && (row < f_vbp(mmode) + f_vact(mmode));
    e_de  = hw && vw;
    ex    = e_de ? mh - f_hbp(mmode) : 0;
    ey    = e_de ? row - f_vbp(mmode) : 0;
    check("R1", "hsync", int'(hs), int'(mh != 0));
    check(mil ? "R4" : "R3", "vsync", int'(vs), int'(e_vs));
    check("R6", "de", int'(de), int'(e_de));
    check("R2", "pix_x", int'(px), ex);
    check(e_fld ? "R5" : "R7", "line_y", int'(ly), ey);
    check("R8", "field", int'(fld), int'(e_fld));
  endtask

  // Advance model with inputs seen at the coming edge, then compare after it
  task automatic step();
    int last;
    last = mil ? 2 * f_vtot(mmode) : f_vtot(mmode) - 1;
    if (mh == f_htot(mmode) - 1) begin
      mh = 0;
      if (mv == last) begin
        mv = 0; mmode = int'(mode); mil = il;
      end else mv++;
    end else mh++;
    @(negedge clk);
    compare();
  endtask

  task automatic run_fixed(int m, bit i);
    int len, n_hs, n_vs, n_de;
    mode = 2'(m); il = i;
    while (!(mh == 0 && mv == 0 && mmode == m && mil == i)) step();
    len = f_frame(m, i);
    n_hs = 0; n_vs = 0; n_de = 0;
    for (int k = 0; k < len; k++) begin
      n_hs += int'(!hs); n_vs += int'(!vs); n_de += int'(de);
      if (k < len - 1) step();
    end
    check("R1", "lines per frame", n_hs, i ? 2 * f_vtot(m) + 1 : f_vtot(m));
    check(i ? "R4" : "R3", "vsync per frame", n_vs, i ? 2 : 1);
    check("R6", "de clocks per frame", n_de, f_hact(m) * f_vact(m) * (i ? 2 : 1));
    step();
  endtask

  initial begin
    int seed_v, cnt;
    seed_v = $urandom(32'h5eed_1234);
    #1;
    // R10: reset state during reset
    check("R10", "hsync in reset", int'(hs), 0);
    check("R10", "vsync in reset", int'(vs), 0);
    check("R10", "de in reset", int'(de), 0);
    check("R10", "field in reset", int'(fld), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();

    for (int m = 0; m < 4; m++) begin
      run_fixed(m, 1'b0);
      run_fixed(m, 1'b1);
    end

    // R9: mid-frame change leaves the running frame untouched
    run_fixed(0, 1'b0);
    while (!(mh == 0 && mv == 0)) step();
    repeat (20) step();
    mode = 2'd3; il = 1'b1;
    cnt = 0;
    do begin step(); cnt++; end while (vs);
    check("R9", "clocks to next vsync", cnt, f_frame(0, 1'b0) - 20);
    check("R9", "new profile after boundary", mmode, 3);

    // R10: asynchronous reset mid-frame
    repeat (37) step();
    rst_n = 1'b0;
    #1;
    check("R10", "hsync after async reset", int'(hs), 0);
    check("R10", "vsync after async reset", int'(vs), 0);
    mode = 2'd0; il = 1'b0;
    @(negedge clk);
    mh = 0; mv = 0; mmode = 0; mil = 1'b0;
    rst_n = 1'b1;
    compare();
    repeat (3) step();
    check("R10", "profile after reset", mmode, 0);

    // Random mode and scan changes
    for (int k = 0; k < 30000; k++) begin
      if ($urandom % 40 == 0) begin
        mode = 2'($urandom % 4);
        il   = 1'($urandom % 2);
      end
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule